// File: doc/BRIEF.md
# Vector ALU Flag Controller

An eight-lane, sixteen-bit-per-lane vector ALU back end. Each cycle it may accept one operation with two source vectors (a plain source `vs` and a pre-shuffled second source `vt`), an opcode and an element field. One clock later it presents a destination vector. At the same edge it updates a per-lane 48-bit accumulator (high, middle and low 16-bit slices) and five per-lane flag masks. Those masks are a carry pair (low and high halves), a compare pair (low and high halves) and a clip-extension mask.

Each opcode has its own rules. They decide which flag halves it reads, replaces or clears, and which accumulator slice it writes or reads back. The operations are saturating add and subtract with carry-in, carry-producing add and subtract, six bitwise forms, merge by compare flag, accumulator read-out and a no-op. Two load operations let the surrounding pipeline set the flag masks and the upper accumulator slices. Lane `i` occupies bits `[16*i+15:16*i]` of every vector, and bit `i` of every flag mask belongs to lane `i`.

Top module: `vec_alu_flags`

## Requirements
- R1: After reset `res_out`, `res_valid`, every flag mask and every accumulator slice are zero. An operation accepted with `op_valid` high appears on `res_out` on the next clock with `res_valid` high. A cycle without `op_valid` drops `res_valid` and holds `res_out`, the flags and the accumulator.
- R2: Opcode 1 (add) forms vs+vt+carry_lo[i] and opcode 2 (subtract) forms vs-vt-carry_lo[i] per lane, both signed. Each returns the result clamped to [-32768, 32767] and clears both carry masks.
- R3: Opcodes 1 and 2 write the unclamped result, wrapped to 16 bits, into the accumulator low slice.
- R4: Opcode 3 (carry add) returns the unsigned 16-bit sum per lane. It also writes that sum into the accumulator low slice, sets carry_lo[i] to the carry-out and clears carry_hi.
- R5: Opcode 4 (carry subtract) returns the unsigned 16-bit difference vs-vt per lane and writes it into the accumulator low slice. It sets carry_lo[i] when the unsigned vs is below vt and sets carry_hi[i] when the operands differ.
- R6: Opcodes 5 to 10 return AND, NAND, OR, NOR, XOR and XNOR of vs and vt, write the result into the accumulator low slice and leave all five flag masks unchanged.
- R7: Opcode 11 (merge) returns vs in lanes where cmp_lo[i] is set and vt elsewhere. It writes the result into the accumulator low slice and clears both carry masks.
- R8: Opcode 12 (read-out) returns the accumulator high slice for element 8, the middle slice for 9, the low slice for 10 and zero for any other element. It changes no flag and no accumulator slice.
- R9: Opcode 0 (no-op) returns vs unchanged and modifies neither flags nor accumulator.
- R10: Opcode 15 (unimplemented) returns an all-zero vector and modifies neither flags nor accumulator.
- R11: Opcode 13 (flag load) returns vs. It loads carry_lo from lane 0 bits 7:0, carry_hi from lane 0 bits 15:8, cmp_lo from lane 1 bits 7:0, cmp_hi from lane 1 bits 15:8 and clip_ext from lane 2 bits 7:0. The accumulator is untouched.
- R12: Opcode 14 (accumulator load) returns vs, loads the high slice from vs and the middle slice from vt, and leaves the low slice and the flags untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation selector |
| elem_sel | input | 4 | Element field, used by read-out |
| vs_in | input | 128 | First source vector |
| vt_in | input | 128 | Second source vector, already shuffled |
| res_out | output | 128 | Destination vector, registered |
| res_valid | output | 1 | res_out holds a new result |
| carry_lo | output | 8 | Carry mask, low half |
| carry_hi | output | 8 | Carry mask, high half |
| cmp_lo | output | 8 | Compare mask, low half |
| cmp_hi | output | 8 | Compare mask, high half |
| clip_ext | output | 8 | Clip-extension mask |

## Verification
The bench aims at the saturation edges: 0x7FFF plus one with a carry-in and 0x8000 minus one. A design that wrapped there would return the opposite sign, while one that stored the clamped value in the accumulator would differ on the next read-out. It also checks that add and subtract really consume carry_lo before clearing it, which catches a design that cleared the mask first or ignored the carry. Equal operands on the carry subtract must leave both carry bits clear; an inverted equality sense would set them. Read-out elements just outside 8 to 10, the unimplemented opcode and the bitwise ops are checked for flag and accumulator side effects, which a design with a loose write enable would corrupt.

// File: rtl/vec_alu_flags.sv
module vec_alu_flags #(
  parameter int LANES = 8,
  parameter int W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [3:0]         op_code,
  input  logic [3:0]         elem_sel,
  input  logic [LANES*W-1:0] vs_in,
  input  logic [LANES*W-1:0] vt_in,
  output logic [LANES*W-1:0] res_out,
  output logic               res_valid,
  output logic [LANES-1:0]   carry_lo,
  output logic [LANES-1:0]   carry_hi,
  output logic [LANES-1:0]   cmp_lo,
  output logic [LANES-1:0]   cmp_hi,
  output logic [LANES-1:0]   clip_ext
);
  localparam int VW = LANES * W;
  localparam logic [3:0] OP_NOP = 4'd0,  OP_ADD = 4'd1,  OP_SUB = 4'd2,  OP_ADDC = 4'd3;
  localparam logic [3:0] OP_SUBC = 4'd4, OP_AND = 4'd5,  OP_NAND = 4'd6, OP_OR = 4'd7;
  localparam logic [3:0] OP_NOR = 4'd8,  OP_XOR = 4'd9,  OP_XNOR = 4'd10, OP_MRG = 4'd11;
  localparam logic [3:0] OP_SAR = 4'd12, OP_FLD = 4'd13, OP_ALD = 4'd14;

  logic [W-1:0] acc_hi [LANES];
  logic [W-1:0] acc_md [LANES];
  logic [W-1:0] acc_lo [LANES];
  logic [W-1:0] lo_n   [LANES];
  logic [W-1:0] hi_n   [LANES];
  logic [W-1:0] md_n   [LANES];
  logic [VW-1:0]    res_n;
  logic [LANES-1:0] clo_n, chi_n, vlo_n, vhi_n, ve_n;

  function automatic logic [W-1:0] clamp(input logic [W:0] x);
    if (x[W] != x[W-1]) return x[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    return x[W-1:0];
  endfunction

  always_comb begin
    res_n = '0;
    clo_n = carry_lo; chi_n = carry_hi;
    vlo_n = cmp_lo;   vhi_n = cmp_hi;   ve_n = clip_ext;
    if (op_code == OP_ADD || op_code == OP_SUB || op_code == OP_MRG) begin
      clo_n = '0; chi_n = '0;
    end
    if (op_code == OP_ADDC || op_code == OP_SUBC) chi_n = '0;
    if (op_code == OP_FLD) begin
      clo_n = vs_in[LANES-1:0];
      chi_n = vs_in[2*LANES-1:LANES];
      vlo_n = vs_in[W +: LANES];
      vhi_n = vs_in[W+LANES +: LANES];
      ve_n  = vs_in[2*W +: LANES];
    end
    for (int i = 0; i < LANES; i++) begin
      logic [W-1:0] a, b, r;
      logic [W:0]   sx, dx, uc, ud;
      a  = vs_in[i*W +: W];
      b  = vt_in[i*W +: W];
      sx = {a[W-1], a} + {b[W-1], b} + {{W{1'b0}}, carry_lo[i]};
      dx = {a[W-1], a} - {b[W-1], b} - {{W{1'b0}}, carry_lo[i]};
      uc = {1'b0, a} + {1'b0, b};
      ud = {1'b0, a} - {1'b0, b};
      hi_n[i] = acc_hi[i];
      md_n[i] = acc_md[i];
      lo_n[i] = acc_lo[i];
      r = '0;
      case (op_code)
        OP_NOP, OP_FLD: r = a;
        OP_ADD:  begin r = clamp(sx); lo_n[i] = sx[W-1:0]; end
        OP_SUB:  begin r = clamp(dx); lo_n[i] = dx[W-1:0]; end
        OP_ADDC: begin r = uc[W-1:0]; lo_n[i] = r; clo_n[i] = uc[W]; end
        OP_SUBC: begin r = ud[W-1:0]; lo_n[i] = r; clo_n[i] = ud[W]; chi_n[i] = (a != b); end
        OP_AND:  begin r = a & b;    lo_n[i] = r; end
        OP_NAND: begin r = ~(a & b); lo_n[i] = r; end
        OP_OR:   begin r = a | b;    lo_n[i] = r; end
        OP_NOR:  begin r = ~(a | b); lo_n[i] = r; end
        OP_XOR:  begin r = a ^ b;    lo_n[i] = r; end
        OP_XNOR: begin r = ~(a ^ b); lo_n[i] = r; end
        OP_MRG:  begin r = cmp_lo[i] ? a : b; lo_n[i] = r; end
        OP_SAR:  r = (elem_sel == 4'd8) ? acc_hi[i] : (elem_sel == 4'd9) ? acc_md[i] :
                     (elem_sel == 4'd10) ? acc_lo[i] : '0;
        OP_ALD:  begin r = a; hi_n[i] = a; md_n[i] = b; end
        default: r = '0;
      endcase
      res_n[i*W +: W] = r;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_out <= '0; res_valid <= 1'b0;
      carry_lo <= '0; carry_hi <= '0; cmp_lo <= '0; cmp_hi <= '0; clip_ext <= '0;
      for (int i = 0; i < LANES; i++) begin
        acc_hi[i] <= '0; acc_md[i] <= '0; acc_lo[i] <= '0;
      end
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_out <= res_n;
        carry_lo <= clo_n; carry_hi <= chi_n;
        cmp_lo <= vlo_n;   cmp_hi <= vhi_n;   clip_ext <= ve_n;
        for (int i = 0; i < LANES; i++) begin
          acc_hi[i] <= hi_n[i]; acc_md[i] <= md_n[i]; acc_lo[i] <= lo_n[i];
        end
      end
    end
  end

  AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid && $stable(res_out) && $stable(carry_lo) && $stable(cmp_lo)); // R1
  AST_ADDSUB_CLEAR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == OP_ADD || op_code == OP_SUB) |=> carry_lo == '0 && carry_hi == '0); // R2
  AST_CARRYADD_HI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_ADDC |=> carry_hi == '0); // R4
  AST_EQUAL_SUB_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_SUBC && vs_in == vt_in |=> carry_lo == '0 && carry_hi == '0 && res_out == '0); // R5
  AST_LOGIC_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code >= OP_AND && op_code <= OP_XNOR |=>
    $stable(carry_lo) && $stable(carry_hi) && $stable(cmp_lo) && $stable(cmp_hi) && $stable(clip_ext)); // R6
  AST_MERGE_CLEAR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_MRG |=> carry_lo == '0 && carry_hi == '0 && $stable(cmp_lo)); // R7
  AST_READOUT_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_SAR && (elem_sel < 4'd8 || elem_sel > 4'd10) |=> res_out == '0); // R8
  AST_NOP_PASSES_VS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_NOP |=> res_out == $past(vs_in) && $stable(carry_lo) && $stable(carry_hi)); // R9
  AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 4'd15 |=> res_out == '0 && $stable(carry_lo) && $stable(cmp_lo) && $stable(clip_ext)); // R10
endmodule

// File: tb/vec_alu_flags_tb_top.sv
`timescale 1ns/1ps
module vec_alu_flags_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0;
  logic [3:0] op_code = '0, elem_sel = '0;
  logic [127:0] vs_in = '0, vt_in = '0, res_out;
  logic res_valid;
  logic [7:0] carry_lo, carry_hi, cmp_lo, cmp_hi, clip_ext;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [15:0] m_hi [8];
  logic [15:0] m_md [8];
  logic [15:0] m_lo [8];
  logic [7:0] m_clo = '0, m_chi = '0, m_vlo = '0, m_vhi = '0, m_ve = '0;

  always #2 clk = ~clk;

  vec_alu_flags dut_i (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .elem_sel(elem_sel), .vs_in(vs_in), .vt_in(vt_in), .res_out(res_out), .res_valid(res_valid),
    .carry_lo(carry_lo), .carry_hi(carry_hi), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi), .clip_ext(clip_ext));

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string tag(input logic [3:0] op);
    case (op)
      4'd0: return "R9";   4'd1, 4'd2: return "R2";  4'd3: return "R4";  4'd4: return "R5";
      4'd11: return "R7";  4'd12: return "R8";  4'd13: return "R11";  4'd14: return "R12";
      4'd15: return "R10"; default: return "R6";
    endcase
  endfunction

  function automatic logic [15:0] sat16(input int s);
    if (s > 32767) return 16'h7FFF;
    if (s < -32768) return 16'h8000;
    return s[15:0];
  endfunction

  task automatic run_op(input logic [3:0] op, input logic [3:0] e, input logic [127:0] a, input logic [127:0] b);
    logic [127:0] er;
    logic [15:0] nlo [8];
    logic [15:0] nhi [8];
    logic [15:0] nmd [8];
    logic [7:0] clo, chi, vlo, vhi, ve;
    string t;
    t = tag(op);
    clo = m_clo; chi = m_chi; vlo = m_vlo; vhi = m_vhi; ve = m_ve;
    if (op == 4'd1 || op == 4'd2 || op == 4'd11) begin clo = '0; chi = '0; end
    if (op == 4'd3 || op == 4'd4) chi = '0;
    if (op == 4'd13) begin
      clo = a[7:0]; chi = a[15:8]; vlo = a[23:16]; vhi = a[31:24]; ve = a[39:32];
    end
    for (int i = 0; i < 8; i++) begin
      logic [15:0] x, y, r;
      int s, u;
      x = a[i*16 +: 16]; y = b[i*16 +: 16];
      nlo[i] = m_lo[i]; nhi[i] = m_hi[i]; nmd[i] = m_md[i];
      r = '0;
      case (op)
        4'd0, 4'd13: r = x;
        4'd1: begin s = int'($signed(x)) + int'($signed(y)) + int'(m_clo[i]); r = sat16(s); nlo[i] = s[15:0]; end
        4'd2: begin s = int'($signed(x)) - int'($signed(y)) - int'(m_clo[i]); r = sat16(s); nlo[i] = s[15:0]; end
        4'd3: begin u = int'(x) + int'(y); r = u[15:0]; nlo[i] = r; clo[i] = (u > 65535); end
        4'd4: begin u = int'(x) - int'(y); r = u[15:0]; nlo[i] = r; clo[i] = (u < 0); chi[i] = (x != y); end
        4'd5: begin r = x & y; nlo[i] = r; end
        4'd6: begin r = ~(x & y); nlo[i] = r; end
        4'd7: begin r = x | y; nlo[i] = r; end
        4'd8: begin r = ~(x | y); nlo[i] = r; end
        4'd9: begin r = x ^ y; nlo[i] = r; end
        4'd10: begin r = ~(x ^ y); nlo[i] = r; end
        4'd11: begin r = m_vlo[i] ? x : y; nlo[i] = r; end
        4'd12: r = (e == 8) ? m_hi[i] : (e == 9) ? m_md[i] : (e == 10) ? m_lo[i] : 16'h0;
        4'd14: begin r = x; nhi[i] = x; nmd[i] = y; end
        default: r = '0;
      endcase
      er[i*16 +: 16] = r;
    end
    op_valid = 1'b1; op_code = op; elem_sel = e; vs_in = a; vt_in = b;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    chk("R1", "valid", {127'd0, res_valid}, 128'd1);
    chk(t, $sformatf("result op%0d", op), res_out, er);
    chk(t, "flags", {88'd0, carry_lo, carry_hi, cmp_lo, cmp_hi, clip_ext}, {88'd0, clo, chi, vlo, vhi, ve});
    m_clo = clo; m_chi = chi; m_vlo = vlo; m_vhi = vhi; m_ve = ve;
    for (int i = 0; i < 8; i++) begin m_lo[i] = nlo[i]; m_hi[i] = nhi[i]; m_md[i] = nmd[i]; end
  endtask

  function automatic logic [127:0] rvec();
    logic [127:0] v;
    for (int i = 0; i < 8; i++) begin
      case ($urandom % 6)
        0: v[i*16 +: 16] = 16'h7FFF;
        1: v[i*16 +: 16] = 16'h8000;
        2: v[i*16 +: 16] = 16'hFFFF;
        3: v[i*16 +: 16] = 16'h0000;
        default: v[i*16 +: 16] = 16'($urandom);
      endcase
    end
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] v;
    void'($urandom(32'd20250611));
    for (int i = 0; i < 8; i++) begin m_hi[i] = '0; m_md[i] = '0; m_lo[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "reset result", res_out, '0);
    chk("R1", "reset flags", {88'd0, carry_lo, carry_hi, cmp_lo, cmp_hi, clip_ext}, '0);
    run_op(4'd12, 4'd8, '0, '0);
    run_op(4'd12, 4'd10, '0, '0);
    // R11 flag load, then R2 carry-in at the saturation edges
    run_op(4'd13, 4'd0, {88'd0, 8'h5A, 8'hF0, 8'h0F, 8'hFF, 8'hFF}, '0);
    run_op(4'd1, 4'd0, {8{16'h7FFF}}, {8{16'h0000}});
    run_op(4'd12, 4'd10, '0, '0); // R3 raw wrapped sum
    run_op(4'd13, 4'd0, {120'd0, 8'hFF}, '0);
    run_op(4'd2, 4'd0, {8{16'h8000}}, {8{16'h0000}});
    run_op(4'd12, 4'd10, '0, '0); // R3
    run_op(4'd3, 4'd0, {8{16'hFFFF}}, {8{16'h0001}});
    run_op(4'd1, 4'd0, {8{16'h0001}}, {8{16'h0001}});
    run_op(4'd4, 4'd0, {8{16'h1234}}, {8{16'h1234}});
    run_op(4'd4, 4'd0, {8{16'h0001}}, {8{16'h0002}});
    run_op(4'd14, 4'd0, {8{16'hA5A5}}, {8{16'h3C3C}});
    for (int e = 7; e <= 11; e++) run_op(4'd12, 4'(e), '0, '0);
    run_op(4'd15, 4'd0, {8{16'hFFFF}}, {8{16'hFFFF}});
    run_op(4'd12, 4'd9, '0, '0);
    run_op(4'd0, 4'd0, {8{16'hBEEF}}, '0);
    run_op(4'd11, 4'd0, {8{16'h1111}}, {8{16'h2222}});
    for (int n = 0; n < 600; n++) begin
      logic [3:0] op, e;
      op = 4'($urandom % 16);
      e = ($urandom % 2) ? 4'(8 + $urandom % 3) : 4'($urandom);
      run_op(op, e, rvec(), rvec());
      if (n % 50 == 0) begin
        @(negedge clk);
        chk("R1", "idle valid", {127'd0, res_valid}, 128'd0);
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule